// File: doc/BRIEF.md
# Packed Command Stream Decoder

This block takes a stream of 32-bit words that carry accelerator commands and sorts them into two kinds of events: register writes and operation triggers. A command word has its 16-bit parameter in the upper half and a 16-bit code field in the lower half. Within the code, bits [15:14] select the payload mode and bits [9:0] hold the opcode. Commands with mode 2'b00 are a single word. Commands with mode 2'b01 take the next accepted word as a full 32-bit value. The opcode is interpreted in one of two spaces, depending on whether the command has a payload.

Single-word commands with an opcode of 0x100 or above write their parameter into a short register bank. Payload commands write their 32-bit value into a long register bank, and their parameter is kept next to it as a 16-bit side field, for example a shift amount. Single-word commands with an opcode below 0x100 are operations. Each operation is held on a trigger port until the consumer accepts it. The stream ends with a stop command (opcode 0x000, parameter 0xFFFF). Illegal modes and payloads cut off by the end of the stream are flagged.

The controller has four states:
- `ST_CMD` waits for a command word.
- `ST_PAY` holds a payload command until its value word arrives.
- `ST_TRIG` presents an operation on the trigger port.
- `ST_DONE` is the idle state after a stop.

Its transitions are:
- `ST_CMD` to `ST_PAY` on a payload command that is not the last word.
- `ST_PAY` to `ST_CMD` on the value word.
- `ST_CMD` to `ST_TRIG` on an operation.
- `ST_TRIG` to `ST_CMD` when the trigger is accepted.
- `ST_CMD` to `ST_DONE` on stop.
- `ST_CMD` stays in `ST_CMD` on a register set, an illegal word or a truncated payload command.

Top module: `cs_decoder`

## Requirements
- R1: After reset, in_ready=1 and wr_valid, trig_valid, done, err_mode and err_trunc are 0. Every register reads back as zero.
- R2: A mode 2'b00 word whose opcode is 0x100 or more makes wr_valid high for one cycle after acceptance, with wr_space=0, wr_idx=opcode[3:0], wr_data={16'h0,param} and wr_extra=0. The short bank entry at that index then reads back the parameter.
- R3: A mode 2'b01 command produces no write when it is accepted. The next accepted word produces a single write with wr_space=1, wr_idx=opcode[3:0], wr_data set to that word and wr_extra set to the command's parameter. The long bank entry then reads back both.
- R4: A mode 2'b00 word whose opcode is below 0x100, other than a stop with parameter 0xFFFF, raises trig_valid with trig_op=opcode and trig_param=param. trig_op and trig_param stay stable and in_ready stays 0 until the cycle after trig_ready is seen high.
- R5: For a DMA start operation (opcode 0x010), trig_dma_mode is param[3:0] and trig_dma_chan is param[15:4].
- R6: A DMA wait operation (opcode 0x011) presents min(param,15) as trig_param. A kernel wait operation (opcode 0x012) presents min(param,3).
- R7: Opcode 0x000 with parameter 0xFFFF sets done, clears in_ready for good and raises no trigger. Opcode 0x000 with any other parameter is an ordinary operation.
- R8: A word with mode 2'b10 or 2'b11 sets err_mode, which then stays set. The word produces no write and no trigger, and it leaves the register banks unchanged.
- R9: A payload command accepted with in_last=1 sets err_trunc, which then stays set. The command is dropped, and the next word is decoded as a new command.
- R10: While in_valid is 0, the input word has no effect on writes, triggers or register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_data | input | 32 | Command or payload word |
| in_last | input | 1 | Marks the final word of the stream |
| wr_valid | output | 1 | One-cycle register write event |
| wr_space | output | 1 | 0 = short bank, 1 = long bank |
| wr_idx | output | IDX_W | Written register index |
| wr_data | output | 32 | Written value |
| wr_extra | output | 16 | Side field (payload commands) |
| trig_valid | output | 1 | Operation trigger pending |
| trig_ready | input | 1 | Consumer accepts the trigger |
| trig_op | output | 10 | Operation opcode |
| trig_param | output | 16 | Operation parameter, clamped for waits |
| trig_dma_chan | output | 12 | DMA channel field |
| trig_dma_mode | output | 4 | DMA mode field |
| rd_space | input | 1 | Read bank select |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | 32 | Read value |
| rd_extra | output | 16 | Read side field |
| done | output | 1 | Stop seen, decoder idle |
| err_mode | output | 1 | Sticky illegal-mode flag |
| err_trunc | output | 1 | Sticky truncated-payload flag |

## Verification
The hardest case to reach is the framing across a stall. A payload command has to sit in `ST_PAY` while the input goes quiet, and its value word must then still land in the right bank with the original parameter as its side field. The stimulus reaches this by sending a payload command, checking that nothing is written in the cycle after it, and only then sending the value word. A truncated payload command is followed at once by a register set, which shows that the decoder went back to command framing and did not treat the next word as the missing payload. Trigger backpressure is covered by holding trig_ready low over several cycles.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int WORD_W  = 32;
    localparam int PARAM_W = 16;
    localparam int OPC_W   = 10;

    localparam logic [1:0] MODE_BARE = 2'b00;
    localparam logic [1:0] MODE_P32  = 2'b01;

    localparam logic [OPC_W-1:0] OPC_STOP      = 10'h000;
    localparam logic [OPC_W-1:0] OPC_DMA_START = 10'h010;
    localparam logic [OPC_W-1:0] OPC_DMA_WAIT  = 10'h011;
    localparam logic [OPC_W-1:0] OPC_KRN_WAIT  = 10'h012;
    localparam logic [OPC_W-1:0] OPC_SET_BASE  = 10'h100;

    localparam logic [PARAM_W-1:0] STOP_MARK    = 16'hFFFF;
    localparam logic [PARAM_W-1:0] DMA_WAIT_MAX = 16'd15;
    localparam logic [PARAM_W-1:0] KRN_WAIT_MAX = 16'd3;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_PAY,
        ST_TRIG,
        ST_DONE
    } cs_state_e;

    typedef enum logic [2:0] {
        CK_SET,
        CK_PAY,
        CK_OP,
        CK_STOP,
        CK_BAD
    } cmd_kind_e;

endpackage

// File: rtl/cs_cmd_decode.sv
module cs_cmd_decode
    import cs_dec_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    output cmd_kind_e          kind,
    output logic [OPC_W-1:0]   opcode,
    output logic [PARAM_W-1:0] param,
    output logic [PARAM_W-1:0] cooked,
    output logic [11:0]        dma_chan,
    output logic [3:0]         dma_mode
);

    logic [1:0] mode;
    logic       unused_bits;

    assign mode        = word[15:14];
    assign opcode      = word[OPC_W-1:0];
    assign param       = word[31:16];
    assign unused_bits = ^word[13:10];
    assign dma_mode    = param[3:0];
    assign dma_chan    = param[15:4];

    always_comb begin
        unique case (mode)
            MODE_BARE: begin
                if (opcode >= OPC_SET_BASE)
                    kind = CK_SET;
                else if (opcode == OPC_STOP && param == STOP_MARK)
                    kind = CK_STOP;
                else
                    kind = CK_OP;
            end
            MODE_P32: kind = CK_PAY;
            default:  kind = CK_BAD;
        endcase
    end

    always_comb begin
        cooked = param;
        if (opcode == OPC_DMA_WAIT && param > DMA_WAIT_MAX)
            cooked = DMA_WAIT_MAX;
        else if (opcode == OPC_KRN_WAIT && param > KRN_WAIT_MAX)
            cooked = KRN_WAIT_MAX;
    end

endmodule

// File: rtl/cs_frame_fsm.sv
module cs_frame_fsm
    import cs_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      in_last,
    input  cmd_kind_e kind,
    input  logic      trig_ready,
    output cs_state_e st,
    output logic      in_ready,
    output logic      trig_valid,
    output logic      done,
    output logic      err_mode,
    output logic      err_trunc,
    output logic      do_set,
    output logic      do_pay,
    output logic      do_trig,
    output logic      hold_cmd
);

    cs_state_e nxt;
    logic      accept;
    logic      mode_hit;
    logic      trunc_hit;

    assign accept = in_valid && in_ready;

    // next-state and event decisions
    always_comb begin
        nxt       = st;
        do_set    = 1'b0;
        do_pay    = 1'b0;
        do_trig   = 1'b0;
        hold_cmd  = 1'b0;
        mode_hit  = 1'b0;
        trunc_hit = 1'b0;
        unique case (st)
            ST_CMD: begin
                if (accept) begin
                    unique case (kind)
                        CK_SET:  do_set = 1'b1;
                        CK_PAY: begin
                            if (in_last) begin
                                trunc_hit = 1'b1;
                            end else begin
                                hold_cmd = 1'b1;
                                nxt      = ST_PAY;
                            end
                        end
                        CK_OP: begin
                            do_trig = 1'b1;
                            nxt     = ST_TRIG;
                        end
                        CK_STOP: nxt = ST_DONE;
                        default: mode_hit = 1'b1;
                    endcase
                end
            end
            ST_PAY: begin
                if (accept) begin
                    do_pay = 1'b1;
                    nxt    = ST_CMD;
                end
            end
            ST_TRIG: begin
                if (trig_ready)
                    nxt = ST_CMD;
            end
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_CMD;
        endcase
    end

    // state register and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_CMD;
            err_mode  <= 1'b0;
            err_trunc <= 1'b0;
        end else begin
            st <= nxt;
            if (mode_hit)
                err_mode <= 1'b1;
            if (trunc_hit)
                err_trunc <= 1'b1;
        end
    end

    // state-derived outputs
    always_comb begin
        in_ready   = (st == ST_CMD) || (st == ST_PAY);
        trig_valid = (st == ST_TRIG);
        done       = (st == ST_DONE);
    end

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !in_ready);

    p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |=> err_mode);

    p_trunc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_trunc |=> err_trunc);

    p_trig_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && !trig_ready) |=> (trig_valid && !in_ready));

endmodule

// File: rtl/cs_reg_file.sv
module cs_reg_file
    import cs_dec_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_space,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [PARAM_W-1:0] wr_extra,
    input  logic               rd_space,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_data,
    output logic [PARAM_W-1:0] rd_extra
);

    logic [PARAM_W-1:0] short_q [NUM_REGS];
    logic [WORD_W-1:0]  long_q  [NUM_REGS];
    logic [PARAM_W-1:0] side_q  [NUM_REGS];
    logic [NUM_REGS-1:0] hit;

    // one-hot write select per entry
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                short_q[i] <= '0;
                long_q[i]  <= '0;
                side_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (hit[i] && !wr_space)
                    short_q[i] <= wr_data[PARAM_W-1:0];
                if (hit[i] && wr_space) begin
                    long_q[i] <= wr_data;
                    side_q[i] <= wr_extra;
                end
            end
        end
    end

    always_comb begin
        if (rd_space) begin
            rd_data  = long_q[rd_idx];
            rd_extra = side_q[rd_idx];
        end else begin
            rd_data  = {{(WORD_W-PARAM_W){1'b0}}, short_q[rd_idx]};
            rd_extra = '0;
        end
    end

    p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_dec_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_data,
    input  logic               in_last,
    output logic               wr_valid,
    output logic               wr_space,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [31:0]        wr_data,
    output logic [15:0]        wr_extra,
    output logic               trig_valid,
    input  logic               trig_ready,
    output logic [9:0]         trig_op,
    output logic [15:0]        trig_param,
    output logic [11:0]        trig_dma_chan,
    output logic [3:0]         trig_dma_mode,
    input  logic               rd_space,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [31:0]        rd_data,
    output logic [15:0]        rd_extra,
    output logic               done,
    output logic               err_mode,
    output logic               err_trunc
);

    cmd_kind_e          dec_kind;
    logic [OPC_W-1:0]   dec_op;
    logic [PARAM_W-1:0] dec_param;
    logic [PARAM_W-1:0] dec_cooked;
    logic [11:0]        dec_chan;
    logic [3:0]         dec_mode;
    cs_state_e          st;
    logic               do_set, do_pay, do_trig, hold_cmd;
    logic [IDX_W-1:0]   held_idx;
    logic [PARAM_W-1:0] held_param;
    logic               fw_en, fw_space;
    logic [IDX_W-1:0]   fw_idx;
    logic [WORD_W-1:0]  fw_data;
    logic [PARAM_W-1:0] fw_extra;

    cs_cmd_decode u_dec (
        .word     (in_data),
        .kind     (dec_kind),
        .opcode   (dec_op),
        .param    (dec_param),
        .cooked   (dec_cooked),
        .dma_chan (dec_chan),
        .dma_mode (dec_mode)
    );

    cs_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .kind       (dec_kind),
        .trig_ready (trig_ready),
        .st         (st),
        .in_ready   (in_ready),
        .trig_valid (trig_valid),
        .done       (done),
        .err_mode   (err_mode),
        .err_trunc  (err_trunc),
        .do_set     (do_set),
        .do_pay     (do_pay),
        .do_trig    (do_trig),
        .hold_cmd   (hold_cmd)
    );

    // write event for this cycle
    always_comb begin
        fw_en    = do_set || do_pay;
        fw_space = do_pay;
        fw_idx   = do_pay ? held_idx : dec_op[IDX_W-1:0];
        fw_data  = do_pay ? in_data : {{(WORD_W-PARAM_W){1'b0}}, dec_param};
        fw_extra = do_pay ? held_param : '0;
    end

    cs_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fw_en),
        .wr_space (fw_space),
        .wr_idx   (fw_idx),
        .wr_data  (fw_data),
        .wr_extra (fw_extra),
        .rd_space (rd_space),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_extra (rd_extra)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid      <= 1'b0;
            wr_space      <= 1'b0;
            wr_idx        <= '0;
            wr_data       <= '0;
            wr_extra      <= '0;
            held_idx      <= '0;
            held_param    <= '0;
            trig_op       <= '0;
            trig_param    <= '0;
            trig_dma_chan <= '0;
            trig_dma_mode <= '0;
        end else begin
            wr_valid <= fw_en;
            if (fw_en) begin
                wr_space <= fw_space;
                wr_idx   <= fw_idx;
                wr_data  <= fw_data;
                wr_extra <= fw_extra;
            end
            if (hold_cmd) begin
                held_idx   <= dec_op[IDX_W-1:0];
                held_param <= dec_param;
            end
            if (do_trig) begin
                trig_op       <= dec_op;
                trig_param    <= dec_cooked;
                trig_dma_chan <= dec_chan;
                trig_dma_mode <= dec_mode;
            end
        end
    end

    p_trig_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && !trig_ready) |=> ($stable(trig_op) && $stable(trig_param)));

    p_pay_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAY) |-> !wr_valid);

    p_bad_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && st == ST_CMD && dec_kind == CK_BAD) |=> (!wr_valid && !trig_valid));

    p_dma_wait_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_op == OPC_DMA_WAIT) |-> (trig_param <= DMA_WAIT_MAX));

    p_krn_wait_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_op == OPC_KRN_WAIT) |-> (trig_param <= KRN_WAIT_MAX));

endmodule

// File: tb/cs_decoder_test.sv
module cs_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        wr_valid, wr_space;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic [15:0] wr_extra;
    logic        trig_valid;
    logic        trig_ready = 1'b0;
    logic [9:0]  trig_op;
    logic [15:0] trig_param;
    logic [11:0] trig_dma_chan;
    logic [3:0]  trig_dma_mode;
    logic        rd_space = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [15:0] rd_extra;
    logic        done, err_mode, err_trunc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .wr_valid(wr_valid),
        .wr_space(wr_space), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_extra(wr_extra), .trig_valid(trig_valid), .trig_ready(trig_ready),
        .trig_op(trig_op), .trig_param(trig_param), .trig_dma_chan(trig_dma_chan),
        .trig_dma_mode(trig_dma_mode), .rd_space(rd_space), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_extra(rd_extra), .done(done),
        .err_mode(err_mode), .err_trunc(err_trunc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic peek(input logic space, input logic [3:0] idx);
        rd_space = space;
        rd_idx   = idx;
        #1;
    endtask

    task automatic release_trig();
        @(negedge clk);
        trig_ready = 1'b1;
        @(negedge clk);
        trig_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 in_ready", in_ready, 1);
        check("R1 wr_valid", wr_valid, 0);
        check("R1 trig_valid", trig_valid, 0);
        check("R1 done", done, 0);
        check("R1 errs", {err_mode, err_trunc}, 0);
        peek(1'b1, 4'd3);
        check("R1 long reg zero", rd_data, 0);
    endtask

    task automatic t_set();
        push({16'h1234, 16'h0105}, 1'b0);
        check("R2 wr_valid", wr_valid, 1);
        check("R2 space", wr_space, 0);
        check("R2 idx", wr_idx, 5);
        check("R2 data", wr_data, 32'h1234);
        peek(1'b0, 4'd5);
        check("R2 readback", rd_data, 32'h1234);
        @(negedge clk);
        check("R2 single pulse", wr_valid, 0);
        push({16'hBEEF, 16'h010F}, 1'b0);
        check("R2 idx high", wr_idx, 4'hF);
    endtask

    task automatic t_payload();
        push({16'h0007, 16'h4103}, 1'b0);
        check("R3 no write on cmd", wr_valid, 0);
        check("R3 ready for payload", in_ready, 1);
        repeat (3) @(negedge clk);
        check("R3 still no write", wr_valid, 0);
        push(32'hDEADBEEF, 1'b0);
        check("R3 wr_valid", wr_valid, 1);
        check("R3 space", wr_space, 1);
        check("R3 idx", wr_idx, 3);
        check("R3 data", wr_data, 32'hDEADBEEF);
        check("R3 extra", wr_extra, 16'h0007);
        peek(1'b1, 4'd3);
        check("R3 readback", rd_data, 32'hDEADBEEF);
        check("R3 readback extra", rd_extra, 16'h0007);
    endtask

    task automatic t_trigger();
        push({16'h0042, 16'h0001}, 1'b0);
        check("R4 trig_valid", trig_valid, 1);
        check("R4 op", trig_op, 10'h001);
        check("R4 param", trig_param, 16'h0042);
        check("R4 in_ready low", in_ready, 0);
        repeat (2) @(negedge clk);
        check("R4 held", {trig_valid, 6'b0, trig_op, trig_param}, {1'b1, 6'b0, 10'h001, 16'h0042});
        release_trig();
        check("R4 released", trig_valid, 0);
        check("R4 ready again", in_ready, 1);
    endtask

    task automatic t_dma();
        push({16'h0035, 16'h0010}, 1'b0);
        check("R5 chan", trig_dma_chan, 3);
        check("R5 mode", trig_dma_mode, 5);
        release_trig();
        push({16'h0A7C, 16'h0010}, 1'b0);
        check("R5 chan wide", trig_dma_chan, 12'h0A7);
        check("R5 mode wide", trig_dma_mode, 4'hC);
        release_trig();
    endtask

    task automatic t_waits();
        push({16'd20, 16'h0011}, 1'b0);
        check("R6 dma wait clamp", trig_param, 15);
        release_trig();
        push({16'd9, 16'h0011}, 1'b0);
        check("R6 dma wait pass", trig_param, 9);
        release_trig();
        push({16'd7, 16'h0012}, 1'b0);
        check("R6 kernel wait clamp", trig_param, 3);
        release_trig();
        push({16'd2, 16'h0012}, 1'b0);
        check("R6 kernel wait pass", trig_param, 2);
        release_trig();
    endtask

    task automatic t_fake_stop();
        push({16'h0001, 16'h0000}, 1'b0);
        check("R7 non-final stop is op", trig_valid, 1);
        check("R7 op zero", trig_op, 0);
        check("R7 not done", done, 0);
        release_trig();
    endtask

    task automatic t_illegal();
        push({16'h5555, 16'h8105}, 1'b0);
        check("R8 err_mode", err_mode, 1);
        check("R8 no write", wr_valid, 0);
        check("R8 no trig", trig_valid, 0);
        peek(1'b0, 4'd5);
        check("R8 reg unchanged", rd_data, 32'h1234);
        push({16'h6666, 16'hC105}, 1'b0);
        check("R8 mode3 no write", wr_valid, 0);
        peek(1'b0, 4'd5);
        check("R8 mode3 reg unchanged", rd_data, 32'h1234);
        check("R8 sticky", err_mode, 1);
    endtask

    task automatic t_trunc();
        push({16'h0009, 16'h4104}, 1'b1);
        check("R9 err_trunc", err_trunc, 1);
        check("R9 no write", wr_valid, 0);
        push({16'h0077, 16'h0104}, 1'b0);
        check("R9 next is command", wr_space, 0);
        peek(1'b0, 4'd4);
        check("R9 short reg", rd_data, 32'h77);
        peek(1'b1, 4'd4);
        check("R9 long reg untouched", rd_data, 0);
        check("R9 sticky", err_trunc, 1);
    endtask

    task automatic t_idle_input();
        @(negedge clk);
        in_data  = {16'h9999, 16'h0105};
        in_valid = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R10 no write", wr_valid, 0);
        end
        peek(1'b0, 4'd5);
        check("R10 reg unchanged", rd_data, 32'h1234);
    endtask

    task automatic t_stop();
        push({16'hFFFF, 16'h0000}, 1'b0);
        check("R7 done", done, 1);
        check("R7 in_ready low", in_ready, 0);
        check("R7 no trig", trig_valid, 0);
        repeat (5) @(negedge clk);
        check("R7 done stays", {done, in_ready}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_payload();
        t_trigger();
        t_dma();
        t_waits();
        t_fake_stop();
        t_illegal();
        t_trunc();
        t_idle_input();
        t_stop();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule